// File: doc/BRIEF.md
# Two-Way Interrupt Bridge Controller

This block sits between a local memory-mapped bus and a PCI interface and carries interrupts across in both directions. Toward PCI, it gathers local events into an outbound status register: a level-type local request line, one pulse input per outbound mailbox (raised whenever that mailbox is written), and a set of error pulses. Each status bit has its own enable bit. While any status bit and its enable are both set, the active-low PCI interrupt output is held low.

Toward the local side, the block samples the active-low PCI interrupt input through a two-flop synchronizer. It records an assertion (high-to-low) and a deassertion (low-to-high) in two separate sticky status bits. Two enable bits, one for each edge type, decide whether either recorded edge drives the local interrupt output. Software can therefore request an interrupt on assertion only, on deassertion only, or on both.

Software reaches the four registers through a single-cycle port. Writes take effect at the clock edge, and read data is a combinational function of the address. Both interrupt outputs are registered.

Top module: `irq_bridge_ctrl`

## Requirements
- R1: Outbound status bit 0 equals the level of `loc_irq_i` sampled at the previous clock edge. Writes do not change it.
- R2: A one on `mbox_wr_i[i]` at a clock edge sets outbound status bit 1+i. That bit stays set until it is cleared.
- R3: A one on `err_pulse_i[j]` at a clock edge sets outbound status bit 1+N_MBOX+j. That bit stays set until it is cleared.
- R4: Writing to the outbound status register (offset 0x0) clears each sticky bit written with one. Bits written with zero keep their value. If a set event and a clear reach the same bit on the same edge, the bit ends up set.
- R5: `pci_inta_n_o` is low in the cycle after one in which some outbound status bit and its enable bit (same position, offset 0x4) are both one. Otherwise it is high.
- R6: `pci_inta_n_i` passes through two synchronizing flops. A high-to-low change sets inbound status bit 0, and a low-to-high change sets inbound status bit 1. The bit is set at the third rising edge after the input changes. Both bits are sticky and are cleared by writing one to offset 0x8. A set wins over a clear in the same cycle.
- R7: `loc_irq_o` is high in the cycle after one in which inbound status bit k and inbound enable bit k (offset 0xC; bit 0 enables assertion edges, bit 1 enables deassertion edges) are both one. Otherwise it is low.
- R8: The enable registers at 0x4 and 0xC read back the value last written to them. Register bits above each register's width read as zero. Any other address reads zero, and writes to it change nothing.
- R9: After reset, all status and enable bits are zero, `pci_inta_n_o` is high and `loc_irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_irq_i | input | 1 | Local interrupt request level |
| mbox_wr_i | input | N_MBOX | Per-mailbox write strobe |
| err_pulse_i | input | N_ERR | Error event pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| pci_inta_n_o | output | 1 | Active-low PCI interrupt output |
| pci_inta_n_i | input | 1 | Active-low PCI interrupt input (asynchronous) |
| loc_irq_o | output | 1 | Local interrupt output |

## Verification
Read data follows the address combinationally, so a corrupted status or enable bit appears at `reg_rdata_o` in the same cycle that its offset is addressed. Through the interrupt outputs it appears one clock later. A lost sticky bit or a clear that wins over a set shows as an interrupt output that drops too early. A synchronizer that is one stage too short or too long moves the inbound status bit and `loc_irq_o` one cycle off the expected edge. The reference model compares both outputs on every clock and compares the addressed register in every cycle, so such a fault shows up within a cycle or two of the stimulus that exposes it.

// File: rtl/irq_bridge_pkg.sv
package irq_bridge_pkg;

    // register byte offsets
    localparam logic [3:0] OFS_OB_STAT = 4'h0;
    localparam logic [3:0] OFS_OB_EN   = 4'h4;
    localparam logic [3:0] OFS_IB_STAT = 4'h8;
    localparam logic [3:0] OFS_IB_EN   = 4'hC;

    // inbound bit positions
    localparam int IB_W    = 2;
    localparam int IB_FALL = 0;
    localparam int IB_RISE = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OB_STAT,
        SEL_OB_EN,
        SEL_IB_STAT,
        SEL_IB_EN
    } reg_sel_e;

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_outbound.sv
module irq_outbound #(
    parameter int N_MBOX = 4,
    parameter int N_ERR  = 2,
    localparam int OB_W  = 1 + N_MBOX + N_ERR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            loc_irq_i,
    input  logic [N_MBOX-1:0] mbox_wr_i,
    input  logic [N_ERR-1:0]  err_i,
    input  logic [OB_W-1:0] clr_i,
    input  logic            en_wr_i,
    input  logic [OB_W-1:0] en_wdata_i,
    output logic [OB_W-1:0] stat_o,
    output logic [OB_W-1:0] en_o,
    output logic            inta_n_o
);

    localparam logic [OB_W-1:0] STICKY = {{(OB_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [OB_W-1:0] stat;
        logic [OB_W-1:0] en;
        logic            inta_n;
    } ob_state_t;

    ob_state_t st_d, st_q;
    logic [OB_W-1:0] set_vec;

    always_comb begin
        st_d        = st_q;
        set_vec     = {err_i, mbox_wr_i, 1'b0};
        st_d.stat   = (((st_q.stat & ~clr_i) | set_vec) & STICKY)
                    | {{(OB_W-1){1'b0}}, loc_irq_i};
        if (en_wr_i) st_d.en = en_wdata_i;
        st_d.inta_n = ~|(st_q.stat & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat   <= '0;
            st_q.en     <= '0;
            st_q.inta_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o   = st_q.stat;
    assign en_o     = st_q.en;
    assign inta_n_o = st_q.inta_n;

    // R1
    level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_o[0] == $past(loc_irq_i)));

    // R2
    mbox_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mbox_wr_i) |=> ((stat_o[N_MBOX:1] & $past(mbox_wr_i)) == $past(mbox_wr_i)));

    // R3
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_i) |=> ((stat_o[OB_W-1:N_MBOX+1] & $past(err_i)) == $past(err_i)));

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(stat_o & ~clr_i) & STICKY)
                  == ($past(stat_o & ~clr_i) & STICKY)));

    // R5
    inta_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_o & en_o)) |=> !inta_n_o);

    // R5
    inta_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_o & en_o)) |=> inta_n_o);

endmodule

// File: rtl/irq_inbound.sv
module irq_inbound
    import irq_bridge_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inta_n_i,
    input  logic [IB_W-1:0] clr_i,
    input  logic            en_wr_i,
    input  logic [IB_W-1:0] en_wdata_i,
    output logic [IB_W-1:0] stat_o,
    output logic [IB_W-1:0] en_o,
    output logic            irq_o
);

    typedef struct packed {
        logic            last;
        logic [IB_W-1:0] stat;
        logic [IB_W-1:0] en;
        logic            irq;
    } ib_state_t;

    ib_state_t st_d, st_q;
    logic      line_sync;
    logic      fall_seen, rise_seen;

    irq_sync2 #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (inta_n_i),
        .sync_o  (line_sync)
    );

    always_comb begin
        st_d      = st_q;
        fall_seen = st_q.last & ~line_sync;
        rise_seen = ~st_q.last & line_sync;
        st_d.last = line_sync;
        st_d.stat = st_q.stat & ~clr_i;
        if (fall_seen) st_d.stat[IB_FALL] = 1'b1;
        if (rise_seen) st_d.stat[IB_RISE] = 1'b1;
        if (en_wr_i) st_d.en = en_wdata_i;
        st_d.irq  = |(st_q.stat & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.last <= 1'b1;
            st_q.stat <= '0;
            st_q.en   <= '0;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.irq;

    // R6
    fall_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(line_sync) && !line_sync) |=> stat_o[IB_FALL]);

    // R6
    rise_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(line_sync) && line_sync) |=> stat_o[IB_RISE]);

    // R7
    local_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(stat_o & en_o))));

endmodule

// File: rtl/irq_bridge_ctrl.sv
module irq_bridge_ctrl
    import irq_bridge_pkg::*;
#(
    parameter int N_MBOX = 4,
    parameter int N_ERR  = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_irq_i,
    input  logic [N_MBOX-1:0] mbox_wr_i,
    input  logic [N_ERR-1:0]  err_pulse_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              pci_inta_n_o,
    input  logic              pci_inta_n_i,
    output logic              loc_irq_o
);

    localparam int OB_W = 1 + N_MBOX + N_ERR;

    reg_sel_e        sel;
    logic [OB_W-1:0] ob_stat, ob_en, ob_clr;
    logic [IB_W-1:0] ib_stat, ib_en, ib_clr;
    logic            ob_en_wr, ib_en_wr;

    always_comb begin
        if      (reg_addr_i == ADDR_W'(OFS_OB_STAT)) sel = SEL_OB_STAT;
        else if (reg_addr_i == ADDR_W'(OFS_OB_EN))   sel = SEL_OB_EN;
        else if (reg_addr_i == ADDR_W'(OFS_IB_STAT)) sel = SEL_IB_STAT;
        else if (reg_addr_i == ADDR_W'(OFS_IB_EN))   sel = SEL_IB_EN;
        else                                         sel = SEL_NONE;
    end

    always_comb begin
        ob_clr   = (reg_wr_i && sel == SEL_OB_STAT) ? reg_wdata_i[OB_W-1:0] : '0;
        ib_clr   = (reg_wr_i && sel == SEL_IB_STAT) ? reg_wdata_i[IB_W-1:0] : '0;
        ob_en_wr = reg_wr_i && (sel == SEL_OB_EN);
        ib_en_wr = reg_wr_i && (sel == SEL_IB_EN);
    end

    irq_outbound #(.N_MBOX(N_MBOX), .N_ERR(N_ERR)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .loc_irq_i  (loc_irq_i),
        .mbox_wr_i  (mbox_wr_i),
        .err_i      (err_pulse_i),
        .clr_i      (ob_clr),
        .en_wr_i    (ob_en_wr),
        .en_wdata_i (reg_wdata_i[OB_W-1:0]),
        .stat_o     (ob_stat),
        .en_o       (ob_en),
        .inta_n_o   (pci_inta_n_o)
    );

    irq_inbound u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .inta_n_i   (pci_inta_n_i),
        .clr_i      (ib_clr),
        .en_wr_i    (ib_en_wr),
        .en_wdata_i (reg_wdata_i[IB_W-1:0]),
        .stat_o     (ib_stat),
        .en_o       (ib_en),
        .irq_o      (loc_irq_o)
    );

    always_comb begin
        unique case (sel)
            SEL_OB_STAT: reg_rdata_o = DATA_W'(ob_stat);
            SEL_OB_EN:   reg_rdata_o = DATA_W'(ob_en);
            SEL_IB_STAT: reg_rdata_o = DATA_W'(ib_stat);
            SEL_IB_EN:   reg_rdata_o = DATA_W'(ib_en);
            default:     reg_rdata_o = '0;
        endcase
    end

    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == ADDR_W'(OFS_OB_EN)) |=> $stable(ob_en));

    // R8
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_W'(OFS_IB_EN))
        |=> (ib_en == $past(reg_wdata_i[IB_W-1:0])));

endmodule

// File: tb/irq_bridge_ctrl_bench.sv
module irq_bridge_ctrl_bench;

    localparam int NM  = 4;
    localparam int NE  = 2;
    localparam int OBW = 1 + NM + NE;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          loc_irq;
    logic [NM-1:0] mbox;
    logic [NE-1:0] err;
    logic          wr;
    logic [3:0]    addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic          inta_n_out;
    logic          inta_n_in;
    logic          irq_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    irq_bridge_ctrl #(.N_MBOX(NM), .N_ERR(NE), .ADDR_W(4), .DATA_W(32)) u_irq_bridge_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .loc_irq_i    (loc_irq),
        .mbox_wr_i    (mbox),
        .err_pulse_i  (err),
        .reg_wr_i     (wr),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .pci_inta_n_o (inta_n_out),
        .pci_inta_n_i (inta_n_in),
        .loc_irq_o    (irq_out)
    );

    // behavioural reference model
    int  m_ob_stat, m_ob_en, m_ib_stat, m_ib_en;
    bit  m_inta_n, m_irq;
    bit  m_pin_hist[$];
    bit  m_prev_sync;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ob_stat = 0; m_ob_en = 0; m_ib_stat = 0; m_ib_en = 0;
            m_inta_n = 1; m_irq = 0; m_prev_sync = 1;
            m_pin_hist = '{1, 1};
        end else begin
            int  n_ob, n_ib, sticky_mask;
            bit  synced;
            sticky_mask = ((1 << OBW) - 1) & ~1;
            m_inta_n = ((m_ob_stat & m_ob_en) == 0);
            m_irq    = ((m_ib_stat & m_ib_en) != 0);
            n_ob = m_ob_stat & sticky_mask;
            if (wr && addr == 4'h0) n_ob = n_ob & ~int'(wdata);
            n_ob = n_ob | (int'(mbox) << 1) | (int'(err) << (1 + NM));
            n_ob = (n_ob & sticky_mask) | int'(loc_irq);
            synced = m_pin_hist[0];
            n_ib = m_ib_stat;
            if (wr && addr == 4'h8) n_ib = n_ib & ~int'(wdata);
            if (m_prev_sync && !synced) n_ib = n_ib | 1;
            if (!m_prev_sync && synced) n_ib = n_ib | 2;
            n_ib = n_ib & 3;
            if (wr && addr == 4'h4) m_ob_en = int'(wdata) & ((1 << OBW) - 1);
            if (wr && addr == 4'hC) m_ib_en = int'(wdata) & 3;
            m_prev_sync = synced;
            void'(m_pin_hist.pop_front());
            m_pin_hist.push_back(inta_n_in);
            m_ob_stat = n_ob;
            m_ib_stat = n_ib;
        end
    end

    function automatic int exp_rd(input logic [3:0] a);
        case (a)
            4'h0:    return m_ob_stat;
            4'h4:    return m_ob_en;
            4'h8:    return m_ib_stat;
            4'hC:    return m_ib_en;
            default: return 0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        case (a)
            4'h0:    return "R1 R2 R3 R4 outbound status";
            4'h4:    return "R8 outbound enable";
            4'h8:    return "R6 inbound status";
            4'hC:    return "R8 inbound enable";
            default: return "R8 unmapped address";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic l, input logic [NM-1:0] mb, input logic [NE-1:0] er,
                       input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic pin);
        @(negedge clk);
        chk("R5 pci interrupt out", 32'(inta_n_out), 32'(m_inta_n));
        chk("R7 local interrupt out", 32'(irq_out), 32'(m_irq));
        loc_irq = l; mbox = mb; err = er; wr = w; addr = a; wdata = d; inta_n_in = pin;
        #1;
        chk(rd_tag(a), rdata, 32'(exp_rd(a)));
    endtask

    task automatic rd(input logic [3:0] a, input logic pin);
        cyc(loc_irq, '0, '0, 1'b0, a, 32'h0, pin);
    endtask

    task automatic wrr(input logic [3:0] a, input logic [31:0] d, input logic pin);
        cyc(loc_irq, '0, '0, 1'b1, a, d, pin);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; loc_irq = 0; mbox = '0; err = '0; wr = 0; addr = 0; wdata = 0; inta_n_in = 1;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset pci interrupt", 32'(inta_n_out), 32'h1);
        chk("R9 reset local interrupt", 32'(irq_out), 32'h0);
        for (int a = 0; a < 16; a += 4) begin
            addr = 4'(a); #1;
            chk("R9 reset register", rdata, 32'h0);
        end
        addr = 0;
        rst_n = 1;

        // R1 level follows, masked without enable (R5)
        loc_irq = 1;
        repeat (4) rd(4'h0, 1);
        // R8 enable write and read back; R5 interrupt drives low
        wrr(4'h4, 32'hFFFF_FFFF, 1);
        repeat (3) rd(4'h4, 1);
        // R1 write one to level bit has no effect
        wrr(4'h0, 32'h1, 1);
        rd(4'h0, 1);
        loc_irq = 0;
        repeat (3) rd(4'h0, 1);
        // R2 mailbox pulse, sticky
        cyc(0, 4'b0100, 2'b00, 0, 4'h0, 0, 1);
        repeat (3) rd(4'h0, 1);
        // R4 write zero keeps, write one clears
        wrr(4'h0, 32'h0, 1);
        rd(4'h0, 1);
        wrr(4'h0, 32'h8, 1);
        repeat (3) rd(4'h0, 1);
        // R4 set wins over simultaneous clear
        cyc(0, 4'b0001, 2'b10, 1, 4'h0, 32'hFFFF_FFFF, 1);
        repeat (3) rd(4'h0, 1);
        // R3 error bits with partial enable
        wrr(4'h4, 32'h40, 1);
        wrr(4'h0, 32'hFF, 1);
        cyc(0, 4'b0000, 2'b01, 0, 4'h0, 0, 1);
        repeat (3) rd(4'h0, 1);
        cyc(0, 4'b0000, 2'b10, 0, 4'h0, 0, 1);
        repeat (3) rd(4'h0, 1);

        // R6 R7 inbound, falling edges only
        wrr(4'hC, 32'h1, 1);
        repeat (6) rd(4'h8, 0);
        repeat (6) rd(4'h8, 1);
        wrr(4'h8, 32'h3, 1);
        repeat (3) rd(4'h8, 1);
        // rising only
        wrr(4'hC, 32'h2, 1);
        repeat (6) rd(4'h8, 0);
        repeat (6) rd(4'h8, 1);
        wrr(4'h8, 32'h2, 1);
        wrr(4'h8, 32'h1, 1);
        // both edges, short pulse
        wrr(4'hC, 32'h3, 1);
        rd(4'h8, 0);
        repeat (6) rd(4'h8, 1);
        wrr(4'h8, 32'h3, 1);
        // no enable: no local interrupt
        wrr(4'hC, 32'h0, 1);
        repeat (6) rd(4'h8, 0);
        repeat (6) rd(4'h8, 1);

        // R8 unmapped writes are ignored
        wrr(4'h2, 32'hFFFF_FFFF, 1);
        wrr(4'h6, 32'hFFFF_FFFF, 1);
        wrr(4'hF, 32'hFFFF_FFFF, 1);
        rd(4'h4, 1); rd(4'hC, 1); rd(4'h0, 1); rd(4'h8, 1); rd(4'h2, 1);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] ra;
            logic       rw, rl, rp;
            ra = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'($urandom_range(0, 3) * 4);
            rw = ($urandom_range(0, 4) == 0);
            rl = ($urandom_range(0, 7) == 0) ? ~loc_irq : loc_irq;
            rp = ($urandom_range(0, 9) == 0) ? ~inta_n_in : inta_n_in;
            cyc(rl, ($urandom_range(0, 5) == 0) ? NM'($urandom) : '0,
                ($urandom_range(0, 7) == 0) ? NE'($urandom) : '0,
                rw, ra, $urandom, rp);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule